// File: doc/BRIEF.md
# Three-Wire Control Register Interface

This block receives 8-bit command words from a host controller over a three-wire serial port: a data line, a shift clock and a latch strobe. All three lines come from outside the system clock domain. Each one is synchronised and edge-detected on the system clock. Every rising edge of the shift clock moves one data bit into an 8-bit shift register. A rising edge of the latch strobe commits the assembled word. The most significant bit of the word picks the target of the commit: either the 7-bit gain register or the mode-flag register, which holds de-emphasis, two bass-shaping bits, mono and channel select.

The block decodes its stored flags into the settings that the audio datapath consumes. These are a bass-boost-active indication and two routing controls that copy one channel onto the other output. A parallel-select input switches the block into pin-strapped operation. In that mode the mute, de-emphasis and bass settings come straight from pins, gain is held at full scale, the output stays in stereo, and the stored registers are left as they were.

Top module: `ctl_serial_port`

## Requirements
- R1: Each synchronised rising edge of `ser_clk` shifts `ser_dat` into the word. Bits arrive first-to-last as D0 to D7. When more than eight pulses come before a latch, only the last eight bits shifted in are kept.
- R2: Stored registers change only on a synchronised rising edge of `ser_latch`. Shifting bits without a latch leaves every output unchanged.
- R3: A committed word with D7 = 0 loads D6..D0 into the gain register, with D6 as the MSB. `gain_code` then shows that value, and the mode flags keep their values.
- R4: A committed word with D7 = 1 loads the mode flags and leaves the gain register unchanged. D5 is de-emphasis, D4 is `bass_sel[1]`, D3 is `bass_sel[0]`, D2 is mono and D1 is channel select. D6 and D0 are ignored.
- R5: In serial mode, `boost_active` is low when `bass_sel` is 2'b11 (flat, unity) and high for 2'b10 (boost minimum), 2'b01 (boost maximum) and 2'b00 (flat, reduced). In parallel mode `boost_active` is low.
- R6: With mono set and channel select set, `left_src_right` is 1, so the right channel feeds both outputs. With mono set and channel select clear, `right_src_left` is 1, so the left channel feeds both outputs. With mono clear, both are 0 (stereo). At most one of the two is ever high.
- R7: When `sel_parallel` is 1, the outputs are driven as follows: `gain_code` is 127, `deemph_en` follows `pin_deemph`, `bass_sel` is {`pin_bb1`,`pin_bb2`}, `mute_req` follows `pin_mute`, and routing is stereo. When `sel_parallel` is 0, `mute_req` is 0.
- R8: Latch strobes that arrive while `sel_parallel` is 1 do not commit. When the block returns to serial mode, the outputs show the register contents from before parallel mode.
- R9: After reset the gain register holds 127, `bass_sel` is 2'b11, de-emphasis is off and the routing is stereo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_parallel | input | 1 | 1 = settings from pins, 0 = settings from serial registers |
| ser_dat | input | 1 | Serial command data |
| ser_clk | input | 1 | Serial shift clock, sampled on its rising edge |
| ser_latch | input | 1 | Latch strobe, commits on its rising edge |
| pin_mute | input | 1 | Parallel-mode mute request |
| pin_deemph | input | 1 | Parallel-mode de-emphasis enable |
| pin_bb1 | input | 1 | Parallel-mode bass select, upper bit |
| pin_bb2 | input | 1 | Parallel-mode bass select, lower bit |
| gain_code | output | 7 | Target gain step, 127 = full scale, 0 = silence |
| deemph_en | output | 1 | De-emphasis enable |
| bass_sel | output | 2 | Bass-shaping mode |
| boost_active | output | 1 | High when a non-unity bass mode is selected from the serial port |
| mute_req | output | 1 | Soft-mute request (parallel mode only) |
| left_src_right | output | 1 | Left output takes the right channel |
| right_src_left | output | 1 | Right output takes the left channel |

## Verification
The bench builds the block with its default parameters: an 8-bit word and a two-stage synchroniser. Every serial level is held for four system clocks, which is longer than the synchroniser delay plus edge detection, so each pulse produces exactly one edge event. The word width is fixed by the command format, so the 8-bit build covers the full gain range 0 to 127 and every flag position. The two-stage depth lets the bench use the same settle wait after every strobe. This same depth also exercises mode switching in the middle of a sequence and over-length shifting.

// File: rtl/ctl_pkg.sv
`timescale 1ns/1ps
package ctl_pkg;

  typedef struct packed {
    logic       deemph;
    logic [1:0] bass;
    logic       mono;
    logic       csel;
  } mode_t;

  localparam logic [1:0] BASS_FLAT_UNITY = 2'b11;

  localparam mode_t MODE_RESET = '{deemph: 1'b0, bass: BASS_FLAT_UNITY,
                                   mono: 1'b0, csel: 1'b0};

  // Non-unity bass shaping in effect.
  function automatic logic bass_active(input logic [1:0] bass);
    return bass != BASS_FLAT_UNITY;
  endfunction

  // Returns {left takes right, right takes left}.
  function automatic logic [1:0] route_decode(input logic mono, input logic csel);
    logic [1:0] r;
    r[1] = mono & csel;
    r[0] = mono & ~csel;
    return r;
  endfunction

  // Extract mode flags from a command word (fixed field positions).
  function automatic mode_t mode_from_word(input logic [7:0] w);
    mode_t m;
    m.deemph = w[5];
    m.bass   = {w[4], w[3]};
    m.mono   = w[2];
    m.csel   = w[1];
    return m;
  endfunction

endpackage

// File: rtl/ctl_edge_sync.sv
`timescale 1ns/1ps
module ctl_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level = chain_q[STAGES-1];
  assign rise  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/ctl_word_shift.sv
`timescale 1ns/1ps
module ctl_word_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word
);
  // New bit enters at the top and moves down; the first bit of the
  // last WORD_W ends up in position 0.
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh_q <= '0;
    else if (shift_en) sh_q <= {bit_in, sh_q[WORD_W-1:1]};
  end

  assign word = sh_q;
endmodule

// File: rtl/ctl_reg_bank.sv
`timescale 1ns/1ps
module ctl_reg_bank
  import ctl_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-2:0] att_q,
  output mode_t             mode_q,
  output logic              commit_att,
  output logic              commit_mode
);
  localparam int ATT_W = WORD_W - 1;
  localparam logic [ATT_W-1:0] FULL_SCALE = '1;

  assign commit_att  = commit & ~word[WORD_W-1];
  assign commit_mode = commit &  word[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          att_q <= FULL_SCALE;
    else if (commit_att) att_q <= word[ATT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mode_q <= MODE_RESET;
    else if (commit_mode) mode_q <= mode_from_word(word[7:0]);
  end
endmodule

// File: rtl/ctl_serial_port.sv
`timescale 1ns/1ps
module ctl_serial_port
  import ctl_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_parallel,
  input  logic              ser_dat,
  input  logic              ser_clk,
  input  logic              ser_latch,
  input  logic              pin_mute,
  input  logic              pin_deemph,
  input  logic              pin_bb1,
  input  logic              pin_bb2,
  output logic [WORD_W-2:0] gain_code,
  output logic              deemph_en,
  output logic [1:0]        bass_sel,
  output logic              boost_active,
  output logic              mute_req,
  output logic              left_src_right,
  output logic              right_src_left
);
  localparam int ATT_W = WORD_W - 1;
  localparam logic [ATT_W-1:0] FULL_SCALE = '1;
  localparam int N_LINES = 3;
  localparam int L_DAT = 0;
  localparam int L_CLK = 1;
  localparam int L_LAT = 2;

  logic [N_LINES-1:0] raw_lines, sync_lvl, sync_rise;
  assign raw_lines = {ser_latch, ser_clk, ser_dat};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    ctl_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_lines[g]),
      .level(sync_lvl[g]),
      .rise (sync_rise[g])
    );
  end

  // Named internal events
  logic shift_evt, latch_evt, commit_att, commit_mode;
  logic [WORD_W-1:0] word;
  logic [ATT_W-1:0]  att_q;
  mode_t             mode_q;

  assign shift_evt = sync_rise[L_CLK];
  assign latch_evt = sync_rise[L_LAT] & ~sel_parallel;

  ctl_word_shift #(.WORD_W(WORD_W)) shift_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(shift_evt),
    .bit_in  (sync_lvl[L_DAT]),
    .word    (word)
  );

  ctl_reg_bank #(.WORD_W(WORD_W)) bank_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (latch_evt),
    .word       (word),
    .att_q      (att_q),
    .mode_q     (mode_q),
    .commit_att (commit_att),
    .commit_mode(commit_mode)
  );

  // Output selection
  logic [1:0] route;
  assign route = route_decode(mode_q.mono, mode_q.csel);

  always_comb begin
    if (sel_parallel) begin
      gain_code      = FULL_SCALE;
      deemph_en      = pin_deemph;
      bass_sel       = {pin_bb1, pin_bb2};
      boost_active   = 1'b0;
      mute_req       = pin_mute;
      left_src_right = 1'b0;
      right_src_left = 1'b0;
    end else begin
      gain_code      = att_q;
      deemph_en      = mode_q.deemph;
      bass_sel       = mode_q.bass;
      boost_active   = bass_active(mode_q.bass);
      mute_req       = 1'b0;
      left_src_right = route[1];
      right_src_left = route[0];
    end
  end
endmodule

// File: rtl/ctl_serial_port_chk.sv
`timescale 1ns/1ps
module ctl_serial_port_chk #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_parallel,
  input logic              commit_att,
  input logic              commit_mode,
  input logic [WORD_W-1:0] word,
  input logic [WORD_W-2:0] att_q,
  input logic [1:0]        bass_sel,
  input logic              boost_active,
  input logic              mute_req,
  input logic              left_src_right,
  input logic              right_src_left
);
  assert_att_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_att |=> att_q == $past(word[WORD_W-2:0]));

  assert_mode_keeps_att_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_mode |=> $stable(att_q));

  assert_att_only_on_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_att |=> $stable(att_q));

  assert_flat_unity_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_parallel && bass_sel == 2'b11) |-> !boost_active);

  assert_route_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({left_src_right, right_src_left}));

  assert_serial_nomute_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_parallel |-> !mute_req);

  assert_par_no_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_parallel |-> !(commit_att || commit_mode));
endmodule

bind ctl_serial_port ctl_serial_port_chk #(.WORD_W(WORD_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .sel_parallel  (sel_parallel),
  .commit_att    (commit_att),
  .commit_mode   (commit_mode),
  .word          (word),
  .att_q         (att_q),
  .bass_sel      (bass_sel),
  .boost_active  (boost_active),
  .mute_req      (mute_req),
  .left_src_right(left_src_right),
  .right_src_left(right_src_left)
);

// File: tb/ctl_serial_port_tb_top.sv
`timescale 1ns/1ps
module ctl_serial_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_parallel = 1'b0;
  logic ser_dat = 1'b0, ser_clk = 1'b0, ser_latch = 1'b0;
  logic pin_mute = 1'b0, pin_deemph = 1'b0, pin_bb1 = 1'b1, pin_bb2 = 1'b1;
  logic [6:0] gain_code;
  logic deemph_en, boost_active, mute_req, left_src_right, right_src_left;
  logic [1:0] bass_sel;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ctl_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .sel_parallel(sel_parallel),
    .ser_dat(ser_dat), .ser_clk(ser_clk), .ser_latch(ser_latch),
    .pin_mute(pin_mute), .pin_deemph(pin_deemph), .pin_bb1(pin_bb1), .pin_bb2(pin_bb2),
    .gain_code(gain_code), .deemph_en(deemph_en), .bass_sel(bass_sel),
    .boost_active(boost_active), .mute_req(mute_req),
    .left_src_right(left_src_right), .right_src_left(right_src_left)
  );

  // {word, gain, deemph, bass, boost, left<-right, right<-left}
  localparam int NV = 8;
  localparam logic [20:0] VEC [NV] = '{
    {8'h00, 7'd0,   1'b0, 2'b11, 1'b0, 1'b0, 1'b0},  // R3 gain to zero
    {8'h55, 7'd85,  1'b0, 2'b11, 1'b0, 1'b0, 1'b0},  // R3 mixed bits
    {8'hA0, 7'd85,  1'b1, 2'b00, 1'b1, 1'b0, 1'b0},  // R4 deemph, flat reduced
    {8'h94, 7'd85,  1'b0, 2'b10, 1'b1, 1'b0, 1'b1},  // R4 R5 R6 mono left
    {8'h8E, 7'd85,  1'b0, 2'b01, 1'b1, 1'b1, 1'b0},  // R4 R5 R6 mono right
    {8'h7F, 7'd127, 1'b0, 2'b01, 1'b1, 1'b1, 1'b0},  // R3 full scale
    {8'hD9, 7'd127, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0},  // R4 D6/D0 ignored, R5
    {8'h01, 7'd1,   1'b0, 2'b11, 1'b0, 1'b0, 1'b0}   // R3 smallest step
  };

  function automatic logic [12:0] pack_out();
    return {gain_code, deemph_en, bass_sel, boost_active, left_src_right, right_src_left};
  endfunction

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [15:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      ser_dat = bits[i];
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
      wait_clk(4);
    end
  endtask

  task automatic pulse_latch();
    ser_latch = 1'b1;
    wait_clk(6);
    ser_latch = 1'b0;
    wait_clk(6);
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(4);
    // R9 reset state
    check("R9", pack_out(), {7'd127, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0});
    check("R7", {12'd0, mute_req}, 13'd0);

    for (int v = 0; v < NV; v++) begin
      send_bits({8'h00, VEC[v][20:13]}, 8);
      pulse_latch();
      check("R1 R3 R4 R5 R6", pack_out(), VEC[v][12:0]);
    end

    // R1 over-length shift: ten bits, first two dropped, word 0x2A kept
    send_bits({6'd0, 8'h2A, 2'b01}, 10);
    pulse_latch();
    check("R1", pack_out(), {7'd42, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0});

    // R2 shifting without a latch changes nothing
    send_bits(16'h008E, 8);
    wait_clk(6);
    check("R2", pack_out(), {7'd42, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0});

    // R7 parallel mode from pins
    pin_mute = 1'b1; pin_deemph = 1'b1; pin_bb1 = 1'b0; pin_bb2 = 1'b1;
    sel_parallel = 1'b1;
    wait_clk(2);
    check("R7 R5", pack_out(), {7'd127, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0});
    check("R7 mute", {12'd0, mute_req}, 13'd1);
    pin_mute = 1'b0;
    wait_clk(1);
    check("R7 mute release", {12'd0, mute_req}, 13'd0);

    // R8 latch in parallel mode (shift register holds 0x8E) is ignored
    pulse_latch();
    send_bits(16'h0011, 8);
    pulse_latch();
    sel_parallel = 1'b0;
    wait_clk(2);
    check("R8", pack_out(), {7'd42, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0});
    check("R7 serial mute", {12'd0, mute_req}, 13'd0);

    // R2 R3 a later latch in serial mode commits the pending word 0x11
    pulse_latch();
    check("R2 R3", pack_out(), {7'd17, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0});

    // R9 reset in mid-operation restores defaults
    send_bits(16'h0086, 8);
    pulse_latch();
    rst_n = 1'b0;
    wait_clk(2);
    rst_n = 1'b1;
    wait_clk(2);
    check("R9 rerun", pack_out(), {7'd127, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0});

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule